// File: doc/BRIEF.md
# I2C Master Register Front End

This block is the software-facing control and status layer of an I2C master. A processor reaches it through a narrow register bus (read strobe, write strobe, a 3-bit offset and 8-bit data) and sees five byte-wide registers: own address, clock divider, control, status and data. The block does not move SCL or SDA itself. Instead it turns register accesses into byte-level operations on a transaction port (START with target byte, SEND byte, RECV byte, STOP), which a separate bit engine carries out and answers.

Writing the data register while no transfer is open launches a START whose byte carries the 7-bit target address in bits 7:1 and the direction in bit 0. Later data writes send bytes. Reading the data register returns the byte fetched earlier and then fetches the next one. Completed operations raise an interrupt-pending flag that software clears by writing zero to it. Dropping the enable bit performs a soft reset that spares only the own-address register. While an operation waits on the port, the block raises `busy_o` and ignores register accesses.

Top module: `i2cm_regfront`

## Requirements
- R1: After hardware reset every register reads 0 except status, which reads 0x80, no transfer is open and `irq_o` is low.
- R2: Offsets are 0 own address (writable mask 0xFE), 1 divider (mask 0x3F), 2 control (mask 0xF4), 3 status, 4 data. Only the masked bits of a write are kept. Offsets 5 to 7 read 0, and writes to them change nothing.
- R3: A control write with bit 7 (enable) clear while enable is set is a soft reset. Divider, control, status (0x80) and the read latch return to reset, the own address is kept, and an open transfer gets a STOP.
- R4: Any other control write stores the masked value. With bit 5 (master) set it sets status bit 5 (bus busy). With bit 5 clear it clears bus busy and closes an open transfer with a STOP.
- R5: A control write with bit 2 (repeated start) and master set while a transfer is open issues a STOP, closes the transfer and leaves bit 2 reading 0.
- R6: Status bit 1 (interrupt pending) and bit 4 (arbitration lost) clear only on a status write with that bit 0 while it is 1. Writing 1 leaves them alone, and no other status bit is writable.
- R7: Interrupt pending is set only while enable is set. `irq_o` equals interrupt pending AND control bit 6 (interrupt enable).
- R8: A data write is ignored unless enable and master are set. With no transfer open it issues START with the written byte. A NACK sets status bit 0 (receive NACK). An ACK clears bit 0, opens the transfer and sets interrupt pending.
- R9: A data write with a transfer open issues SEND. A NACK sets bit 0, closes the transfer with a STOP and leaves interrupt pending alone. An ACK clears bit 0 and sets interrupt pending.
- R10: A data read returns the latched byte. In master mode it then latches 0xFF when no transfer is open or control bit 4 (transmit) is set. Otherwise it issues RECV, latches the received byte and sets interrupt pending.
- R11: Operations use codes 0 START, 1 SEND, 2 RECV, 3 STOP. `cmd_valid_o` holds with stable code and byte until `cmd_ready_i`. Every operation except STOP then waits for `ans_valid_i`. `busy_o` is high from the cycle after a launching access until the result is applied, and accesses made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_off_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| busy_o | output | 1 | Port operation outstanding, accesses ignored |
| irq_o | output | 1 | Level interrupt |
| cmd_valid_o | output | 1 | Operation request valid |
| cmd_ready_i | input | 1 | Operation request accepted |
| cmd_op_o | output | 2 | Operation code |
| cmd_byte_o | output | 8 | Target byte for START, data byte for SEND |
| ans_valid_i | input | 1 | Operation answer valid |
| ans_nack_i | input | 1 | Answer was a NACK |
| ans_byte_i | input | 8 | Received byte for RECV |

## Verification
Sequencing is tried with target bytes that match and miss the responding address, with data bytes the target accepts and the one it refuses, and with reads made with no transfer open, in transmit direction and in receive direction. Together these separate the START, SEND, RECV and 0xFF paths and the STOP that follows a refusal. Control writes cover soft reset, master drop and repeated start, each with and without an open transfer, so a missing or extra STOP shows in the count. A random phase mixes all offsets and masks under random port latency, and every read is compared to a bench model.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int DW    = 8;
  localparam int OFF_W = 3;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  localparam logic [OFF_W-1:0] OFF_OWN = 3'd0;
  localparam logic [OFF_W-1:0] OFF_DIV = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CTL = 3'd2;
  localparam logic [OFF_W-1:0] OFF_STS = 3'd3;
  localparam logic [OFF_W-1:0] OFF_DAT = 3'd4;

  localparam logic [DW-1:0] MASK_OWN = 8'hFE;
  localparam logic [DW-1:0] MASK_DIV = 8'h3F;
  localparam logic [DW-1:0] MASK_CTL = 8'hF4;
  localparam logic [DW-1:0] STS_RST  = 8'h80;
  localparam logic [DW-1:0] BYTE_IDLE = 8'hFF;

  // control bit positions
  localparam int C_EN  = 7;
  localparam int C_IE  = 6;
  localparam int C_MST = 5;
  localparam int C_TX  = 4;
  localparam int C_RS  = 2;
  // status bit positions
  localparam int S_BUSY = 5;
  localparam int S_ARB  = 4;
  localparam int S_PEND = 1;
  localparam int S_NACK = 0;
endpackage

// File: rtl/i2cm_link.sv
module i2cm_link
  import i2cm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_go_i,
  input  op_e           op_kind_i,
  input  logic [DW-1:0] op_byte_i,
  output logic          op_done_o,
  output logic          op_nack_o,
  output logic [DW-1:0] op_rx_o,
  output logic          busy_o,
  output logic          cmd_valid_o,
  input  logic          cmd_ready_i,
  output logic [1:0]    cmd_op_o,
  output logic [DW-1:0] cmd_byte_o,
  input  logic          ans_valid_i,
  input  logic          ans_nack_i,
  input  logic [DW-1:0] ans_byte_i
);
  typedef enum logic [1:0] {L_IDLE, L_REQ, L_WAIT} lst_e;

  lst_e          st_q, st_n;
  op_e           op_q, op_n;
  logic [DW-1:0] byte_q, byte_n;
  logic          done_q, done_n;
  logic          nack_q, nack_n;
  logic [DW-1:0] rx_q, rx_n;

  always_comb begin
    st_n   = st_q;
    op_n   = op_q;
    byte_n = byte_q;
    done_n = 1'b0;
    nack_n = nack_q;
    rx_n   = rx_q;
    unique case (st_q)
      L_IDLE: if (op_go_i) begin
        st_n   = L_REQ;
        op_n   = op_kind_i;
        byte_n = op_byte_i;
      end
      L_REQ: if (cmd_ready_i) st_n = (op_q == OP_STOP) ? L_IDLE : L_WAIT;
      L_WAIT: if (ans_valid_i) begin
        st_n   = L_IDLE;
        done_n = 1'b1;
        nack_n = ans_nack_i;
        rx_n   = ans_byte_i;
      end
      default: st_n = L_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= L_IDLE;
      op_q   <= OP_STOP;
      byte_q <= '0;
      done_q <= 1'b0;
      nack_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      st_q   <= st_n;
      op_q   <= op_n;
      byte_q <= byte_n;
      done_q <= done_n;
      nack_q <= nack_n;
      rx_q   <= rx_n;
    end
  end

  assign cmd_valid_o = (st_q == L_REQ);
  assign cmd_op_o    = op_q;
  assign cmd_byte_o  = byte_q;
  assign busy_o      = (st_q != L_IDLE) || done_q;
  assign op_done_o   = done_q;
  assign op_nack_o   = nack_q;
  assign op_rx_o     = rx_q;

  // R11: request held stable until accepted
  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_byte_o)));

  // R11: a new operation only arrives while the port is free
  a_r11_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
    op_go_i |-> (st_q == L_IDLE));
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_wr_i,
  input  logic             acc_rd_i,
  input  logic [OFF_W-1:0] acc_off_i,
  input  logic [DW-1:0]    acc_wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o,
  output logic             op_go_o,
  output op_e              op_kind_o,
  output logic [DW-1:0]    op_byte_o,
  input  logic             op_done_i,
  input  logic             op_nack_i,
  input  logic [DW-1:0]    op_rx_i
);
  logic [DW-1:0] own_q, own_n, div_q, div_n, ctl_q, ctl_n, sts_q, sts_n;
  logic [DW-1:0] latch_q, latch_n, rdata_q, rdata_n;
  logic          open_q, open_n;
  op_e           kind_q, kind_n;
  logic          go;
  op_e           kind;
  logic [DW-1:0] gbyte;
  logic [DW-1:0] wd;

  assign wd = acc_wdata_i;

  always_comb begin
    own_n = own_q; div_n = div_q; ctl_n = ctl_q; sts_n = sts_q;
    latch_n = latch_q; rdata_n = rdata_q; open_n = open_q;
    go = 1'b0; kind = OP_STOP; gbyte = '0;

    if (op_done_i) begin
      unique case (kind_q)
        OP_START: if (op_nack_i) sts_n[S_NACK] = 1'b1;
                  else begin
                    sts_n[S_NACK] = 1'b0;
                    open_n = 1'b1;
                    if (ctl_q[C_EN]) sts_n[S_PEND] = 1'b1;
                  end
        OP_SEND:  if (op_nack_i) begin
                    sts_n[S_NACK] = 1'b1;
                    open_n = 1'b0;
                    go = 1'b1;
                    kind = OP_STOP;
                  end else begin
                    sts_n[S_NACK] = 1'b0;
                    if (ctl_q[C_EN]) sts_n[S_PEND] = 1'b1;
                  end
        OP_RECV:  begin
                    latch_n = op_rx_i;
                    if (ctl_q[C_EN]) sts_n[S_PEND] = 1'b1;
                  end
        default: ;
      endcase
    end

    if (acc_wr_i) begin
      case (acc_off_i)
        OFF_OWN: own_n = wd & MASK_OWN;
        OFF_DIV: div_n = wd & MASK_DIV;
        OFF_CTL: begin
          if (ctl_q[C_EN] && !wd[C_EN]) begin
            div_n = '0; ctl_n = '0; sts_n = STS_RST; latch_n = '0; open_n = 1'b0;
            if (open_q) go = 1'b1;
          end else begin
            ctl_n = wd & MASK_CTL;
            if (wd[C_MST]) sts_n[S_BUSY] = 1'b1;
            else begin
              sts_n[S_BUSY] = 1'b0;
              if (open_q) begin go = 1'b1; open_n = 1'b0; end
            end
            if (wd[C_RS] && wd[C_MST] && open_q) begin
              go = 1'b1; open_n = 1'b0; ctl_n[C_RS] = 1'b0;
            end
          end
        end
        OFF_STS: begin
          if (sts_q[S_PEND] && !wd[S_PEND]) sts_n[S_PEND] = 1'b0;
          if (sts_q[S_ARB]  && !wd[S_ARB])  sts_n[S_ARB]  = 1'b0;
        end
        OFF_DAT: if (ctl_q[C_EN] && ctl_q[C_MST]) begin
          go = 1'b1;
          kind = open_q ? OP_SEND : OP_START;
          gbyte = wd;
        end
        default: ;
      endcase
    end

    if (acc_rd_i) begin
      case (acc_off_i)
        OFF_OWN: rdata_n = own_q;
        OFF_DIV: rdata_n = div_q;
        OFF_CTL: rdata_n = ctl_q;
        OFF_STS: rdata_n = sts_q;
        OFF_DAT: begin
          rdata_n = latch_q;
          if (ctl_q[C_MST]) begin
            if (!open_q || ctl_q[C_TX]) latch_n = BYTE_IDLE;
            else begin go = 1'b1; kind = OP_RECV; end
          end
        end
        default: rdata_n = '0;
      endcase
    end

    kind_n = go ? kind : kind_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0; div_q <= '0; ctl_q <= '0; sts_q <= STS_RST;
      latch_q <= '0; rdata_q <= '0; open_q <= 1'b0; kind_q <= OP_STOP;
    end else begin
      own_q <= own_n; div_q <= div_n; ctl_q <= ctl_n; sts_q <= sts_n;
      latch_q <= latch_n; rdata_q <= rdata_n; open_q <= open_n; kind_q <= kind_n;
    end
  end

  assign rdata_o   = rdata_q;
  assign irq_o     = sts_q[S_PEND] & ctl_q[C_IE];
  assign op_go_o   = go;
  assign op_kind_o = kind;
  assign op_byte_o = gbyte;

  // R6: write-zero clears interrupt pending
  a_r6_pend_w0c: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr_i && acc_off_i == OFF_STS && sts_q[S_PEND] && !acc_wdata_i[S_PEND]) |=> !sts_q[S_PEND]);

  // R7: pending rises only while enabled
  a_r7_pend_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[S_PEND]) |-> ctl_q[C_EN]);

  // R9: refused data byte closes the transfer and flags NACK
  a_r9_nack_close: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done_i && kind_q == OP_SEND && op_nack_i) |=> (!open_q && sts_q[S_NACK]));

  // R5: repeated start on an open transfer self-clears and closes it
  a_r5_rs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr_i && acc_off_i == OFF_CTL && !(ctl_q[C_EN] && !acc_wdata_i[C_EN])
     && acc_wdata_i[C_RS] && acc_wdata_i[C_MST] && open_q) |=> (!ctl_q[C_RS] && !open_q));
endmodule

// File: rtl/i2cm_regfront.sv
module i2cm_regfront
  import i2cm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [OFF_W-1:0] reg_off_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             busy_o,
  output logic             irq_o,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [1:0]       cmd_op_o,
  output logic [DW-1:0]    cmd_byte_o,
  input  logic             ans_valid_i,
  input  logic             ans_nack_i,
  input  logic [DW-1:0]    ans_byte_i
);
  logic          acc_wr, acc_rd, busy;
  logic          op_go, op_done, op_nack;
  op_e           op_kind;
  logic [DW-1:0] op_byte, op_rx;

  assign acc_wr = reg_wr_i & ~busy;
  assign acc_rd = reg_rd_i & ~busy;
  assign busy_o = busy;

  i2cm_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .acc_wr_i(acc_wr), .acc_rd_i(acc_rd), .acc_off_i(reg_off_i), .acc_wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .irq_o(irq_o),
    .op_go_o(op_go), .op_kind_o(op_kind), .op_byte_o(op_byte),
    .op_done_i(op_done), .op_nack_i(op_nack), .op_rx_i(op_rx)
  );

  i2cm_link u_link (
    .clk(clk), .rst_n(rst_n),
    .op_go_i(op_go), .op_kind_i(op_kind), .op_byte_i(op_byte),
    .op_done_o(op_done), .op_nack_o(op_nack), .op_rx_o(op_rx), .busy_o(busy),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_op_o(cmd_op_o),
    .cmd_byte_o(cmd_byte_o), .ans_valid_i(ans_valid_i), .ans_nack_i(ans_nack_i),
    .ans_byte_i(ans_byte_i)
  );
endmodule

// File: tb/i2cm_regfront_tb_top.sv
module i2cm_regfront_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_off = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic busy, irq;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic ans_valid = 1'b0, ans_nack = 1'b0;
  logic [7:0] ans_byte = '0;

  always #5 clk = ~clk;

  i2cm_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_off_i(reg_off),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .busy_o(busy), .irq_o(irq),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op), .cmd_byte_o(cmd_byte),
    .ans_valid_i(ans_valid), .ans_nack_i(ans_nack), .ans_byte_i(ans_byte)
  );

  int n_chk = 0, n_bad = 0;
  int n_ops = 0, n_stop = 0, n_recv = 0;
  bit finished = 1'b0;

  // bench model state
  logic [7:0] m_own, m_div, m_ctl, m_sts, m_latch;
  bit m_open;
  int m_rxc, m_stop;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_own = 0; m_div = 0; m_ctl = 0; m_sts = 8'h80; m_latch = 0; m_open = 0; m_rxc = 0; m_stop = 0;
  endtask

  task automatic m_write(logic [2:0] off, logic [7:0] d);
    case (off)
      3'd0: m_own = d & 8'hFE;
      3'd1: m_div = d & 8'h3F;
      3'd2: if (m_ctl[7] && !d[7]) begin
              if (m_open) m_stop++;
              m_div = 0; m_ctl = 0; m_sts = 8'h80; m_latch = 0; m_open = 0;
            end else begin
              m_ctl = d & 8'hF4;
              if (m_ctl[5]) m_sts[5] = 1;
              else begin m_sts[5] = 0; if (m_open) begin m_stop++; m_open = 0; end end
              if (m_ctl[2] && m_open) begin m_stop++; m_open = 0; m_ctl[2] = 0; end
            end
      3'd3: begin
              if (m_sts[1] && !d[1]) m_sts[1] = 0;
              if (m_sts[4] && !d[4]) m_sts[4] = 0;
            end
      3'd4: if (m_ctl[7] && m_ctl[5]) begin
              if (!m_open) begin
                if (d[7:1] == 7'h50) begin m_sts[0] = 0; m_open = 1; m_sts[1] = 1; end
                else m_sts[0] = 1;
              end else if (d == 8'hEE) begin
                m_sts[0] = 1; m_open = 0; m_stop++;
              end else begin m_sts[0] = 0; m_sts[1] = 1; end
            end
      default: ;
    endcase
  endtask

  function automatic logic [7:0] m_peek(logic [2:0] off);
    case (off)
      3'd0: return m_own;
      3'd1: return m_div;
      3'd2: return m_ctl;
      3'd3: return m_sts;
      3'd4: return m_latch;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_read_effect(logic [2:0] off);
    if (off == 3'd4 && m_ctl[5]) begin
      if (!m_open || m_ctl[4]) m_latch = 8'hFF;
      else begin
        m_latch = 8'h30 + 8'(m_rxc); m_rxc++;
        if (m_ctl[7]) m_sts[1] = 1;
      end
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic bus_wr(logic [2:0] off, logic [7:0] d);
    wait_idle();
    reg_wr = 1; reg_off = off; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    m_write(off, d);
  endtask

  task automatic bus_rd(logic [2:0] off, string tag);
    logic [7:0] exp;
    wait_idle();
    reg_rd = 1; reg_off = off;
    @(negedge clk);
    reg_rd = 0;
    exp = m_peek(off);
    chk(tag, reg_rdata, exp);
    m_read_effect(off);
  endtask

  task automatic chk_irq(string tag);
    wait_idle();
    chk(tag, {7'd0, irq}, {7'd0, m_sts[1] & m_ctl[6]});
  endtask

  task automatic chk_stops(string tag);
    wait_idle();
    @(negedge clk);
    chk(tag, 8'(n_stop), 8'(m_stop));
  endtask

  // target responder: accepts address 0x50, refuses data byte 0xEE
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid && rst_n) begin
        logic [1:0] op;
        logic [7:0] b;
        repeat ($urandom % 3) @(negedge clk);
        cmd_ready = 1; op = cmd_op; b = cmd_byte;
        @(negedge clk);
        cmd_ready = 0;
        n_ops++;
        if (op == 2'd3) n_stop++;
        else begin
          repeat ($urandom % 3) @(negedge clk);
          ans_valid = 1;
          ans_nack = (op == 2'd0) ? (b[7:1] != 7'h50) : (op == 2'd1) ? (b == 8'hEE) : 1'b0;
          ans_byte = 8'h30 + 8'(n_recv);
          if (op == 2'd2) n_recv++;
          @(negedge clk);
          ans_valid = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ops_before;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 5; i++) bus_rd(3'(i), "R1");
    chk_irq("R1");

    // R2 masks and unmapped offsets
    bus_wr(0, 8'hFF); bus_rd(0, "R2");
    bus_wr(1, 8'hFF); bus_rd(1, "R2");
    bus_wr(2, 8'h5F); bus_rd(2, "R2"); bus_rd(3, "R4");
    bus_wr(5, 8'hFF); bus_wr(7, 8'hAA);
    for (int i = 5; i < 8; i++) bus_rd(3'(i), "R2");
    bus_rd(0, "R2"); bus_rd(1, "R2");

    // R8 ignored while disabled
    bus_wr(2, 8'h20);
    ops_before = n_ops;
    bus_wr(4, 8'hA0);
    repeat (6) @(negedge clk);
    chk("R8 no op when disabled", 8'(n_ops), 8'(ops_before));
    bus_rd(3, "R8");

    // R8 refused then accepted target, R11 busy
    bus_wr(2, 8'hF0);
    bus_wr(4, 8'hB4); bus_rd(3, "R8");
    reg_wr = 1; reg_off = 4; reg_wdata = 8'hA0;
    @(negedge clk); reg_wr = 0; m_write(4, 8'hA0);
    chk("R11 busy after launch", {7'd0, busy}, 8'h01);
    bus_rd(3, "R8"); chk_irq("R7");

    // R6 write-1 keeps, write-0 clears
    bus_wr(3, 8'hFF); bus_rd(3, "R6"); chk_irq("R6");
    bus_wr(3, 8'h00); bus_rd(3, "R6"); chk_irq("R6");

    // R9 ack then nack
    bus_wr(4, 8'h11); bus_rd(3, "R9");
    bus_wr(3, 8'h00);
    bus_wr(4, 8'hEE); bus_rd(3, "R9"); chk_stops("R9 stop after nack");

    // R10 reads with no transfer open and in receive
    bus_rd(4, "R10"); bus_rd(4, "R10");
    bus_wr(2, 8'hE0); bus_wr(4, 8'hA1);
    bus_rd(4, "R10"); bus_rd(4, "R10"); bus_rd(3, "R10");
    bus_wr(2, 8'hF0); bus_rd(4, "R10"); bus_rd(4, "R10");

    // R5 repeated start
    bus_wr(2, 8'hF4); bus_rd(2, "R5"); chk_stops("R5 stop");
    bus_wr(2, 8'hE4); bus_wr(4, 8'hA1); bus_wr(2, 8'hE4); bus_rd(2, "R5"); chk_stops("R5 stop");

    // R4 master drop closes transfer
    bus_wr(2, 8'hE0); bus_wr(4, 8'hA0);
    bus_wr(2, 8'hC0); bus_rd(3, "R4"); chk_stops("R4 stop");

    // R3 soft reset keeps own address
    bus_wr(0, 8'h6C); bus_wr(1, 8'h15);
    bus_wr(2, 8'hE0); bus_wr(4, 8'hA0);
    bus_wr(2, 8'h00);
    for (int i = 0; i < 5; i++) bus_rd(3'(i), "R3");
    chk_stops("R3 stop"); chk_irq("R3");

    // R7 pending without interrupt enable
    bus_wr(2, 8'hA0); bus_wr(4, 8'hA0); bus_rd(3, "R7"); chk_irq("R7");
    bus_wr(2, 8'hE0); chk_irq("R7");

    // random phase
    for (int k = 0; k < 400; k++) begin
      int sel = $urandom % 10;
      logic [2:0] off = 3'($urandom % 8);
      logic [7:0] d = 8'($urandom);
      if (sel < 4) begin
        case ($urandom % 5)
          0: d = 8'hA0; 1: d = 8'hA1; 2: d = 8'hEE; 3: d = 8'h11; default: ;
        endcase
        bus_wr(4, d);
      end else if (sel < 5) begin
        if ($urandom % 5 != 0) d[7] = 1'b1;
        if ($urandom % 4 != 0) d[5] = 1'b1;
        bus_wr(2, d);
      end else if (sel < 6) bus_wr(off, d);
      else bus_rd(off, "R10 random");
      if (k % 8 == 0) begin bus_rd(3, "R9 random"); chk_irq("R7 random"); end
    end
    chk_stops("R11 random stops");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule